// File: doc/BRIEF.md
# Three-Entry Weight Reorder Unit

This unit puts three mixture entries back into order of decreasing weight after a per-pixel update has changed exactly one of them. Each entry has a mean and a weight. The two entries that were not touched are still in order relative to each other. Because of that, the changed entry only has to be placed into the right slot. Two compare-exchange stages do this, and no full sorting network is needed. The unit also tracks which of three storage banks holds each entry, and it produces a 3-bit order code. The next frame uses that code to read the banks from heaviest entry to lightest.

The code that came with the pixel is decoded into the bank held at each old rank. The slot index of the updated entry names the bank that moved. The new bank order is encoded back into a code. A small combinational decoder turns the incoming code and a phase number into a one-hot bank enable, so the banks can be read one per phase. Results are registered and appear one cycle after the input strobe, together with a ready strobe.

Top module: `reorder3_top`

## Requirements
- R1: While reset is asserted, and after it is released with no input strobe, `out_valid` is 0, `code_out` is 000, and all output means and weights are 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0.
- R3: On an accepted input, the three output entries are the two untouched entries and the updated entry, with output weights non-increasing from slot 0 to slot 2. The two untouched entries keep their relative order. This requires `hi_wgt` >= `lo_wgt`.
- R4: When the updated weight equals an untouched weight, the untouched entry takes the higher rank (the lower slot number).
- R5: An order code lists the banks in reading order. Banks are numbered 1 to 3. 000 is 1,2,3; 001 is 1,3,2; 010 is 2,1,3; 011 is 2,3,1; 100 is 3,1,2; 101 is 3,2,1. The incoming code gives the bank at each old rank. `code_out` gives the bank of each output slot in this encoding, and `code_out` is never 110 or 111.
- R6: An incoming code of 110 or 111 is handled exactly as 000.
- R7: `upd_idx` gives the old rank (0, 1 or 2) of the updated entry, and the untouched entries fill the other two ranks in order. A value of 3 is handled as 2.
- R8: While `in_valid` is 0, `code_out`, `out_mean` and `out_wgt` keep their values.
- R9: `bank_en` is combinational from `code_in` and `phase`. For phase p in 0..2 it has exactly one bit set: bit k-1 for bank k, where bank k is entry p of the code's reading order. For phase 3 it is 000. Codes 110 and 111 decode as 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input entries are valid this cycle |
| code_in | input | 3 | Bank order code of the previous ranking |
| upd_idx | input | 2 | Old rank of the updated entry |
| hi_mean | input | MEAN_W | Mean of the higher-ranked untouched entry |
| hi_wgt | input | WGT_W | Weight of the higher-ranked untouched entry |
| lo_mean | input | MEAN_W | Mean of the lower-ranked untouched entry |
| lo_wgt | input | WGT_W | Weight of the lower-ranked untouched entry |
| upd_mean | input | MEAN_W | Mean of the updated entry |
| upd_wgt | input | WGT_W | Weight of the updated entry |
| phase | input | 2 | Read phase selecting a bank enable |
| bank_en | output | 3 | One-hot bank enable for the phase |
| out_valid | output | 1 | Ready strobe, one cycle after in_valid |
| out_mean | output | 3*MEAN_W | Means by new rank, slot 0 in low bits |
| out_wgt | output | 3*WGT_W | Weights by new rank, slot 0 in low bits |
| code_out | output | 3 | New bank order code |

## Verification
The ordering checks assume that on every accepted input the untouched weights are already ordered (`hi_wgt` >= `lo_wgt`). An input-side property watches this, because the single-insertion scheme gives no ordering guarantee without it. The stimulus draws the untouched pair only from combinations that satisfy this. It sweeps the updated weight through values below, between, equal to and above that pair, so that every insertion slot and both tie cases are reached. All eight incoming codes and all four index values are crossed with these weights, so the illegal code and the illegal index are exercised alongside the legal ones.

// File: rtl/reorder3_pkg.sv
package reorder3_pkg;
  localparam int NUM_ENT  = 3;
  localparam int CODE_W   = 3;
  localparam int BANK_W   = 2;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_LAST = 3'd5;
endpackage

// File: rtl/reorder3_code_dec.sv
module reorder3_code_dec
  import reorder3_pkg::*;
(
  input  code_t                      code_i,
  output logic [NUM_ENT-1:0][BANK_W-1:0] bank_o
);
  code_t c_eff;
  bank_t first, rest_lo, rest_hi;

  always_comb begin
    c_eff = (code_i > CODE_LAST) ? '0 : code_i;
    first = c_eff[2:1];
    case (first)
      2'd0:    begin rest_lo = 2'd1; rest_hi = 2'd2; end
      2'd1:    begin rest_lo = 2'd0; rest_hi = 2'd2; end
      default: begin rest_lo = 2'd0; rest_hi = 2'd1; end
    endcase
    bank_o[0] = first;
    bank_o[1] = c_eff[0] ? rest_hi : rest_lo;
    bank_o[2] = c_eff[0] ? rest_lo : rest_hi;
  end
endmodule

// File: rtl/reorder3_code_enc.sv
module reorder3_code_enc
  import reorder3_pkg::*;
(
  input  logic [NUM_ENT-1:0][BANK_W-1:0] bank_i,
  output code_t                          code_o
);
  always_comb begin
    code_o = {bank_i[0], (bank_i[1] > bank_i[2])};
  end
endmodule

// File: rtl/reorder3_cmpx.sv
module reorder3_cmpx
  import reorder3_pkg::*;
#(
  parameter int MEAN_W = 8,
  parameter int WGT_W  = 8
) (
  input  logic [MEAN_W-1:0] x_mean,
  input  logic [WGT_W-1:0]  x_wgt,
  input  bank_t             x_bank,
  input  logic              x_upd,
  input  logic [MEAN_W-1:0] y_mean,
  input  logic [WGT_W-1:0]  y_wgt,
  input  bank_t             y_bank,
  input  logic              y_upd,
  output logic [MEAN_W-1:0] hi_mean,
  output logic [WGT_W-1:0]  hi_wgt,
  output bank_t             hi_bank,
  output logic              hi_upd,
  output logic [MEAN_W-1:0] lo_mean,
  output logic [WGT_W-1:0]  lo_wgt,
  output bank_t             lo_bank,
  output logic              lo_upd
);
  logic x_wins;

  always_comb begin
    // a tie goes to x unless x is the freshly updated entry
    x_wins = (x_wgt > y_wgt) || ((x_wgt == y_wgt) && !x_upd);
    if (x_wins) begin
      hi_mean = x_mean; hi_wgt = x_wgt; hi_bank = x_bank; hi_upd = x_upd;
      lo_mean = y_mean; lo_wgt = y_wgt; lo_bank = y_bank; lo_upd = y_upd;
    end else begin
      hi_mean = y_mean; hi_wgt = y_wgt; hi_bank = y_bank; hi_upd = y_upd;
      lo_mean = x_mean; lo_wgt = x_wgt; lo_bank = x_bank; lo_upd = x_upd;
    end
  end
endmodule

// File: rtl/reorder3_bank_sel.sv
module reorder3_bank_sel
  import reorder3_pkg::*;
(
  input  logic [NUM_ENT-1:0][BANK_W-1:0] bank_i,
  input  logic [1:0]                     phase_i,
  output logic [NUM_ENT-1:0]             en_o
);
  always_comb begin
    en_o = '0;
    for (int p = 0; p < NUM_ENT; p++) begin
      if (phase_i == 2'(p)) en_o = NUM_ENT'(1) << bank_i[p];
    end
  end

  always_comb begin
    assert ($countones(en_o) <= 1) else $error("AST_BANK_ONEHOT"); // R9
  end
endmodule

// File: rtl/reorder3_top.sv
module reorder3_top
  import reorder3_pkg::*;
#(
  parameter int MEAN_W = 8,
  parameter int WGT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2:0]                code_in,
  input  logic [1:0]                upd_idx,
  input  logic [MEAN_W-1:0]         hi_mean,
  input  logic [WGT_W-1:0]          hi_wgt,
  input  logic [MEAN_W-1:0]         lo_mean,
  input  logic [WGT_W-1:0]          lo_wgt,
  input  logic [MEAN_W-1:0]         upd_mean,
  input  logic [WGT_W-1:0]          upd_wgt,
  input  logic [1:0]                phase,
  output logic [2:0]                bank_en,
  output logic                      out_valid,
  output logic [3*MEAN_W-1:0]       out_mean,
  output logic [3*WGT_W-1:0]        out_wgt,
  output logic [2:0]                code_out
);
  localparam logic [1:0] LAST_IDX = 2'(NUM_ENT - 1);

  logic [NUM_ENT-1:0][BANK_W-1:0] old_bank;
  logic [NUM_ENT-1:0][BANK_W-1:0] new_bank;
  logic [1:0] idx_eff;
  bank_t      a_bank, b_bank, u_bank;

  // stage wiring: s1 = upd against hi entry, s2 = loser against lo entry
  logic [MEAN_W-1:0] s1h_mean, s1l_mean, s2h_mean, s2l_mean;
  logic [WGT_W-1:0]  s1h_wgt,  s1l_wgt,  s2h_wgt,  s2l_wgt;
  bank_t             s1h_bank, s1l_bank, s2h_bank, s2l_bank;
  logic              s1h_upd,  s1l_upd,  s2h_upd,  s2l_upd;

  code_t             code_nxt;
  logic [3*MEAN_W-1:0] mean_nxt;
  logic [3*WGT_W-1:0]  wgt_nxt;
  logic [3*MEAN_W-1:0] mean_q;
  logic [3*WGT_W-1:0]  wgt_q;
  code_t               code_q;
  logic                valid_q;

  reorder3_code_dec u_dec (
    .code_i (code_in),
    .bank_o (old_bank)
  );

  reorder3_bank_sel u_sel (
    .bank_i  (old_bank),
    .phase_i (phase),
    .en_o    (bank_en)
  );

  always_comb begin
    idx_eff = (upd_idx > LAST_IDX) ? LAST_IDX : upd_idx;
    u_bank  = old_bank[idx_eff];
    a_bank  = (idx_eff == 2'd0) ? old_bank[1] : old_bank[0];
    b_bank  = (idx_eff == 2'd2) ? old_bank[1] : old_bank[2];
  end

  reorder3_cmpx #(.MEAN_W(MEAN_W), .WGT_W(WGT_W)) u_stage1 (
    .x_mean (hi_mean),  .x_wgt (hi_wgt),  .x_bank (a_bank), .x_upd (1'b0),
    .y_mean (upd_mean), .y_wgt (upd_wgt), .y_bank (u_bank), .y_upd (1'b1),
    .hi_mean(s1h_mean), .hi_wgt(s1h_wgt), .hi_bank(s1h_bank), .hi_upd(s1h_upd),
    .lo_mean(s1l_mean), .lo_wgt(s1l_wgt), .lo_bank(s1l_bank), .lo_upd(s1l_upd)
  );

  reorder3_cmpx #(.MEAN_W(MEAN_W), .WGT_W(WGT_W)) u_stage2 (
    .x_mean (s1l_mean), .x_wgt (s1l_wgt), .x_bank (s1l_bank), .x_upd (s1l_upd),
    .y_mean (lo_mean),  .y_wgt (lo_wgt),  .y_bank (b_bank),   .y_upd (1'b0),
    .hi_mean(s2h_mean), .hi_wgt(s2h_wgt), .hi_bank(s2h_bank), .hi_upd(s2h_upd),
    .lo_mean(s2l_mean), .lo_wgt(s2l_wgt), .lo_bank(s2l_bank), .lo_upd(s2l_upd)
  );

  always_comb begin
    new_bank[0] = s1h_bank;
    new_bank[1] = s2h_bank;
    new_bank[2] = s2l_bank;
  end

  reorder3_code_enc u_enc (
    .bank_i (new_bank),
    .code_o (code_nxt)
  );

  always_comb begin
    mean_nxt = {s2l_mean, s2h_mean, s1h_mean};
    wgt_nxt  = {s2l_wgt,  s2h_wgt,  s1h_wgt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mean_q  <= '0;
      wgt_q   <= '0;
      code_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        mean_q <= mean_nxt;
        wgt_q  <= wgt_nxt;
        code_q <= code_nxt;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_mean  = mean_q;
  assign out_wgt   = wgt_q;
  assign code_out  = code_q;

  AST_INPUT_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (hi_wgt >= lo_wgt)) else $error("AST_INPUT_ORDERED"); // R3
  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("AST_READY_RISE"); // R2
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("AST_READY_IDLE"); // R2
  AST_OUT_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wgt[WGT_W-1:0] >= out_wgt[2*WGT_W-1:WGT_W]) &&
                  (out_wgt[2*WGT_W-1:WGT_W] >= out_wgt[3*WGT_W-1:2*WGT_W]))
    else $error("AST_OUT_SORTED"); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_out <= CODE_LAST) else $error("AST_CODE_LEGAL"); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(code_out) && $stable(out_wgt) && $stable(out_mean)))
    else $error("AST_HOLD"); // R8
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |-> (bank_en == 3'b000)) else $error("AST_PHASE_IDLE"); // R9
endmodule

// File: tb/sim_reorder3_top.sv
module sim_reorder3_top;
  localparam int MW = 8;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] code_in = '0;
  logic [1:0] upd_idx = '0;
  logic [MW-1:0] hi_mean = '0, lo_mean = '0, upd_mean = '0;
  logic [WW-1:0] hi_wgt = '0, lo_wgt = '0, upd_wgt = '0;
  logic [1:0] phase = 2'd3;
  logic [2:0] bank_en;
  logic out_valid;
  logic [3*MW-1:0] out_mean;
  logic [3*WW-1:0] out_wgt;
  logic [2:0] code_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  reorder3_top #(.MEAN_W(MW), .WGT_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code_in(code_in),
    .upd_idx(upd_idx), .hi_mean(hi_mean), .hi_wgt(hi_wgt),
    .lo_mean(lo_mean), .lo_wgt(lo_wgt), .upd_mean(upd_mean),
    .upd_wgt(upd_wgt), .phase(phase), .bank_en(bank_en),
    .out_valid(out_valid), .out_mean(out_mean), .out_wgt(out_wgt),
    .code_out(code_out)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reading order of banks (0-based) for each legal code
  function automatic int perm_at(input int c, input int pos);
    int t [6][3];
    t[0] = '{0,1,2}; t[1] = '{0,2,1}; t[2] = '{1,0,2};
    t[3] = '{1,2,0}; t[4] = '{2,0,1}; t[5] = '{2,1,0};
    if (c > 5) c = 0;
    return t[c][pos];
  endfunction

  function automatic int code_of(input int b0, input int b1, input int b2);
    for (int c = 0; c < 6; c++)
      if (perm_at(c,0) == b0 && perm_at(c,1) == b1 && perm_at(c,2) == b2) return c;
    return 7;
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R2 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int wset [3];
    int uset [6];
    wset = '{9, 6, 3};
    uset = '{0, 3, 5, 6, 9, 12};

    repeat (3) @(negedge clk);
    check("R1 reset valid", out_valid, 0);
    check("R1 reset code", code_out, 0);
    check("R1 reset wgt", out_wgt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", out_valid, 0);
    check("R1 idle mean", out_mean, 0);

    // R9: bank enable sweep
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        code_in = 3'(c);
        phase = 2'(p);
        #1;
        check((c > 5) ? "R9 R6 bank_en" : "R9 bank_en", bank_en,
              (p == 3) ? 0 : (1 << perm_at(c, p)));
      end
    end
    phase = 2'd3;

    for (int c = 0; c < 8; c++) begin
      for (int ix = 0; ix < 4; ix++) begin
        for (int ia = 0; ia < 3; ia++) begin
          for (int ib = ia; ib < 3; ib++) begin
            for (int iu = 0; iu < 6; iu++) begin
              int wa, wb, wu, pos, ie;
              int ob [3];
              int ab, bb, ub;
              int ew [3], em [3], ebk [3];
              longint exp_w, exp_m;
              logic [2:0] held_code;
              logic [3*WW-1:0] held_w;

              wa = wset[ia]; wb = wset[ib]; wu = uset[iu];
              ie = (ix == 3) ? 2 : ix;
              for (int k = 0; k < 3; k++) ob[k] = perm_at(c, k);
              ub = ob[ie];
              ab = (ie == 0) ? ob[1] : ob[0];
              bb = (ie == 2) ? ob[1] : ob[2];
              // R4: untouched entry wins a tie
              pos = ((wa >= wu) ? 1 : 0) + ((wb >= wu) ? 1 : 0);
              if (pos == 0) begin
                ew = '{wu, wa, wb}; em = '{33, 11, 22}; ebk = '{ub, ab, bb};
              end else if (pos == 1) begin
                ew = '{wa, wu, wb}; em = '{11, 33, 22}; ebk = '{ab, ub, bb};
              end else begin
                ew = '{wa, wb, wu}; em = '{11, 22, 33}; ebk = '{ab, bb, ub};
              end
              exp_w = longint'(ew[0]) | (longint'(ew[1]) << WW) | (longint'(ew[2]) << (2*WW));
              exp_m = longint'(em[0]) | (longint'(em[1]) << MW) | (longint'(em[2]) << (2*MW));

              in_valid = 1'b1;
              code_in = 3'(c); upd_idx = 2'(ix);
              hi_mean = 8'd11; hi_wgt = 8'(wa);
              lo_mean = 8'd22; lo_wgt = 8'(wb);
              upd_mean = 8'd33; upd_wgt = 8'(wu);
              @(negedge clk);
              check("R2 ready", out_valid, 1);
              check((wu == wa || wu == wb) ? "R4 R3 weights" : "R3 weights", out_wgt, exp_w);
              check((ix == 3) ? "R7 R3 means" : "R3 means", out_mean, exp_m);
              check((c > 5) ? "R6 R5 code" : "R5 code", code_out, code_of(ebk[0], ebk[1], ebk[2]));
              held_code = code_out;
              held_w = out_wgt;

              in_valid = 1'b0;
              code_in = 3'(7 - c); upd_idx = 2'(3 - ix);
              hi_wgt = 8'd200; lo_wgt = 8'd100; upd_wgt = 8'd150;
              @(negedge clk);
              check("R2 idle", out_valid, 0);
              check("R8 hold code", code_out, held_code);
              check("R8 hold wgt", out_wgt, held_w);
            end
          end
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule